// File: doc/BRIEF.md
# Thread Run-State Controller

This block keeps the run state of a set of hardware thread contexts and acts on three kinds of request aimed at one context: a yield, a halt and a restore. Each context holds an active flag and a restart address. A halt stops an active context and records the address it would have executed next. A restore restarts a stopped context. It loads a program counter triple built from the stored restart address, and the block announces that load with a one-cycle strobe.

A yield carries a signed source operand and a qualifier mask. The block sorts the operand by sign and value. Zero releases the calling context. A positive value is a qualified wait, and it is checked against the mask. The value minus two is a plain scheduling hint. Any other negative value is a scheduler-intercepted hint. Each path that can go wrong raises its own exception code with a one-cycle fault pulse. Every yield also returns the operand masked by the qualifier mask. All results are registered and appear one clock after the request.

The per-context eligibility flags, the dirty flags and the intercept enable come in as inputs. They are owned by the surrounding control state.

Top module: `thy_ctrl`

## Requirements
- R1: After reset, `ctx_active` equals parameter `ACT_RST`. `fault`, `pc_load` and `exc_code` are 0, and every restart address equals `RESET_PC`.
- R2: A yield with source 0 clears the caller's active bit one cycle later, but only when the caller has `ctx_bind_ok`, `ctx_dyn_alloc`, no `ctx_halt_hold`, and is active. In every other case the active bits do not change. A zero-source yield never faults.
- R3: A yield with a positive source that sets any bit outside `yield_mask` gives `exc_code` = 2 and a `fault` pulse. A positive source within the mask gives `exc_code` = 0 and no fault.
- R4: A yield with a negative source other than −2 gives `exc_code` = 4 and a `fault` pulse when `sched_intercept` is 1 and the caller's `ctx_dirty` bit is 1. A source of −2, or a cleared intercept or dirty bit, gives `exc_code` = 0 and no fault.
- R5: One cycle after any yield, `yield_result` equals `yield_src & yield_mask`. The value holds until the next yield.
- R6: A halt to an active context clears its active bit and stores `cur_npc` as that context's restart address.
- R7: A restore to an inactive context sets its active bit and pulses `pc_load` for one cycle. In that cycle `pc_load_ctx` is the context, `pc_out` is the restart address, `npc_out` is the restart address + `PC_STEP` and `nnpc_out` is the restart address + 2·`PC_STEP`, all modulo 2^`XLEN`.
- R8: A halt to an inactive context, or a restore to an active one, changes no active bit and no restart address. It gives no `pc_load` and no fault, and sets `exc_code` to 0.
- R9: `fault` lasts one cycle. `exc_code` keeps its value through cycles with no request and is rewritten by every request.
- R10: When several strobes are high together, only one of them is served. Yield wins over halt, and halt wins over restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_yield | input | 1 | Yield request strobe |
| req_halt | input | 1 | Halt request strobe |
| req_restore | input | 1 | Restore request strobe |
| req_ctx | input | CW | Target or calling context |
| yield_src | input | XLEN | Signed yield source operand |
| yield_mask | input | XLEN | Allowed yield qualifier bits |
| cur_npc | input | XLEN | Next PC of the context being halted |
| ctx_bind_ok | input | NCTX | Context is bound to its own processor and slot |
| ctx_dyn_alloc | input | NCTX | Context is dynamically allocatable |
| ctx_halt_hold | input | NCTX | Context halt-hold flag |
| ctx_dirty | input | NCTX | Context dirty flag |
| sched_intercept | input | 1 | Scheduler intercept enable for negative yields |
| ctx_active | output | NCTX | Active flag per context |
| yield_result | output | XLEN | Masked yield operand |
| exc_code | output | 3 | Exception code of the last request |
| fault | output | 1 | One-cycle fault pulse |
| pc_load | output | 1 | One-cycle strobe that a PC triple is loaded |
| pc_load_ctx | output | CW | Context receiving the PC triple |
| pc_out | output | XLEN | Restored PC |
| npc_out | output | XLEN | Restored next PC |
| nnpc_out | output | XLEN | Restored next-next PC |

## Verification
The bench builds the block with four contexts and 16-bit operands, with `PC_STEP` = 4, `ACT_RST` = 4'b0011, `RESET_PC` = 16'h0100 and parallel adders. The narrow width makes −2 (16'hFFFE) and other negative hints easy to write. It also lets a restart address of 16'hFFFC show the next-PC sums wrapping to 0 and 4. Because the reset activity is mixed, some contexts start stopped. Restoring one of them exposes the reset restart address, and requests to contexts that are already in the requested state show the no-effect paths.

// File: rtl/thy_pkg.sv
package thy_pkg;

   // Exception codes reported on exc_code (values are part of the interface)
   typedef enum logic [2:0] {
      EXC_NONE  = 3'd0,
      EXC_QUAL  = 3'd2,
      EXC_SCHED = 3'd4
   } thy_exc_e;

   typedef enum logic [1:0] {
      OP_IDLE,
      OP_YIELD,
      OP_HALT,
      OP_RESTORE
   } thy_op_e;

   // Fixed priority among simultaneous strobes: yield, then halt, then restore
   function automatic thy_op_e thy_pick_op(input logic y, input logic h, input logic r);
      thy_op_e op;
      if (y)      op = OP_YIELD;
      else if (h) op = OP_HALT;
      else if (r) op = OP_RESTORE;
      else        op = OP_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/thy_yield_decode.sv
module thy_yield_decode
   import thy_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] src,
   input  logic [XLEN-1:0] mask,
   input  logic            caller_ready,
   input  logic            caller_dirty,
   input  logic            intercept,
   output logic            dealloc,
   output thy_exc_e        exc,
   output logic [XLEN-1:0] result
);

   // Two's complement -2: the plain scheduling hint that never traps
   localparam logic [XLEN-1:0] HINT_PLAIN = {{(XLEN-1){1'b1}}, 1'b0};

   logic is_zero;
   logic is_neg;
   logic excess;

   assign is_zero = (src == '0);
   assign is_neg  = src[XLEN-1];
   assign excess  = |(src & ~mask);
   assign result  = src & mask;

   always_comb begin
      dealloc = 1'b0;
      exc     = EXC_NONE;
      if (is_zero) begin
         dealloc = caller_ready;
      end else if (!is_neg) begin
         if (excess) exc = EXC_QUAL;
      end else if (src != HINT_PLAIN) begin
         if (intercept && caller_dirty) exc = EXC_SCHED;
      end
   end

endmodule

// File: rtl/thy_ctx_slot.sv
module thy_ctx_slot #(
   parameter int              XLEN     = 32,
   parameter bit              RST_ACT  = 1'b0,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_req,
   input  logic            restore_req,
   input  logic            dealloc_req,
   input  logic [XLEN-1:0] save_pc,
   output logic            active,
   output logic [XLEN-1:0] restart
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= RST_ACT;
         restart <= RESET_PC;
      end else if (halt_req && active) begin
         active  <= 1'b0;
         restart <= save_pc;
      end else if (restore_req && !active) begin
         active  <= 1'b1;
      end else if (dealloc_req && active) begin
         active  <= 1'b0;
      end
   end

endmodule

// File: rtl/thy_pc_seq.sv
module thy_pc_seq #(
   parameter int XLEN    = 32,
   parameter int PC_STEP = 4,
   parameter bit CHAIN   = 1'b0
) (
   input  logic [XLEN-1:0] base,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] npc,
   output logic [XLEN-1:0] nnpc
);

   localparam logic [XLEN-1:0] STEP1 = XLEN'(PC_STEP);
   localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * PC_STEP);

   assign pc  = base;
   assign npc = base + STEP1;

   generate
      if (CHAIN) begin : g_chain
         assign nnpc = npc + STEP1;
      end else begin : g_parallel
         assign nnpc = base + STEP2;
      end
   endgenerate

endmodule

// File: rtl/thy_ctrl.sv
module thy_ctrl
   import thy_pkg::*;
#(
   parameter int               NCTX         = 4,
   parameter int               XLEN         = 32,
   parameter int               PC_STEP      = 4,
   parameter logic [NCTX-1:0]  ACT_RST      = NCTX'(1),
   parameter logic [XLEN-1:0]  RESET_PC     = '0,
   parameter bit               CHAIN_ADDERS = 1'b0,
   localparam int              CW           = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_yield,
   input  logic            req_halt,
   input  logic            req_restore,
   input  logic [CW-1:0]   req_ctx,
   input  logic [XLEN-1:0] yield_src,
   input  logic [XLEN-1:0] yield_mask,
   input  logic [XLEN-1:0] cur_npc,
   input  logic [NCTX-1:0] ctx_bind_ok,
   input  logic [NCTX-1:0] ctx_dyn_alloc,
   input  logic [NCTX-1:0] ctx_halt_hold,
   input  logic [NCTX-1:0] ctx_dirty,
   input  logic            sched_intercept,
   output logic [NCTX-1:0] ctx_active,
   output logic [XLEN-1:0] yield_result,
   output logic [2:0]      exc_code,
   output logic            fault,
   output logic            pc_load,
   output logic [CW-1:0]   pc_load_ctx,
   output logic [XLEN-1:0] pc_out,
   output logic [XLEN-1:0] npc_out,
   output logic [XLEN-1:0] nnpc_out
);

   // Elaboration-time parameter checks
   generate
      if (NCTX < 2) begin : g_bad_nctx
         $error("thy_ctrl: NCTX must be at least 2");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("thy_ctrl: XLEN must be at least 8");
      end
      if (PC_STEP <= 0 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("thy_ctrl: PC_STEP must be a positive power of two");
      end
   endgenerate

   thy_op_e         op;
   logic            ctx_ok;
   logic            sel_active;
   logic            sel_ready;
   logic            sel_dirty;
   logic [XLEN-1:0] sel_restart;
   logic            dec_dealloc;
   thy_exc_e        dec_exc;
   logic [XLEN-1:0] dec_result;
   logic            restore_hit;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] seq_npc;
   logic [XLEN-1:0] seq_nnpc;
   logic [XLEN-1:0] restart_vec [NCTX];
   thy_exc_e        exc_q;

   assign op     = thy_pick_op(req_yield, req_halt, req_restore);
   assign ctx_ok = (32'(req_ctx) < NCTX);

   assign sel_active  = ctx_ok && ctx_active[req_ctx];
   assign sel_dirty   = ctx_ok && ctx_dirty[req_ctx];
   assign sel_ready   = sel_active && ctx_bind_ok[req_ctx] &&
                        ctx_dyn_alloc[req_ctx] && !ctx_halt_hold[req_ctx];
   assign sel_restart = ctx_ok ? restart_vec[req_ctx] : RESET_PC;
   assign restore_hit = (op == OP_RESTORE) && ctx_ok && !sel_active;

   thy_yield_decode #(
      .XLEN(XLEN)
   ) u_decode (
      .src         (yield_src),
      .mask        (yield_mask),
      .caller_ready(sel_ready),
      .caller_dirty(sel_dirty),
      .intercept   (sched_intercept),
      .dealloc     (dec_dealloc),
      .exc         (dec_exc),
      .result      (dec_result)
   );

   // One state slot per context
   generate
      for (genvar i = 0; i < NCTX; i++) begin : g_slot
         logic hit;
         assign hit = ctx_ok && (32'(req_ctx) == i);

         thy_ctx_slot #(
            .XLEN    (XLEN),
            .RST_ACT (ACT_RST[i]),
            .RESET_PC(RESET_PC)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .halt_req   (hit && (op == OP_HALT)),
            .restore_req(hit && (op == OP_RESTORE)),
            .dealloc_req(hit && (op == OP_YIELD) && dec_dealloc),
            .save_pc    (cur_npc),
            .active     (ctx_active[i]),
            .restart    (restart_vec[i])
         );
      end
   endgenerate

   thy_pc_seq #(
      .XLEN   (XLEN),
      .PC_STEP(PC_STEP),
      .CHAIN  (CHAIN_ADDERS)
   ) u_pcseq (
      .base(sel_restart),
      .pc  (seq_pc),
      .npc (seq_npc),
      .nnpc(seq_nnpc)
   );

   // Registered result stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_q        <= EXC_NONE;
         fault        <= 1'b0;
         yield_result <= '0;
         pc_load      <= 1'b0;
         pc_load_ctx  <= '0;
         pc_out       <= '0;
         npc_out      <= '0;
         nnpc_out     <= '0;
      end else begin
         fault   <= 1'b0;
         pc_load <= 1'b0;
         if (op != OP_IDLE) begin
            exc_q <= (op == OP_YIELD) ? dec_exc : EXC_NONE;
         end
         if (op == OP_YIELD) begin
            yield_result <= dec_result;
            fault        <= (dec_exc != EXC_NONE);
         end
         if (restore_hit) begin
            pc_load     <= 1'b1;
            pc_load_ctx <= req_ctx;
            pc_out      <= seq_pc;
            npc_out     <= seq_npc;
            nnpc_out    <= seq_nnpc;
         end
      end
   end

   assign exc_code = exc_q;

endmodule

// File: rtl/thy_ctrl_chk.sv
module thy_ctrl_chk #(
   parameter int  NCTX    = 4,
   parameter int  XLEN    = 32,
   parameter int  PC_STEP = 4,
   localparam int CW      = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_yield,
   input logic            req_halt,
   input logic            req_restore,
   input logic [CW-1:0]   req_ctx,
   input logic [XLEN-1:0] yield_src,
   input logic [XLEN-1:0] yield_mask,
   input logic [NCTX-1:0] ctx_bind_ok,
   input logic [NCTX-1:0] ctx_dyn_alloc,
   input logic [NCTX-1:0] ctx_halt_hold,
   input logic            sched_intercept,
   input logic [NCTX-1:0] ctx_active,
   input logic [XLEN-1:0] yield_result,
   input logic [2:0]      exc_code,
   input logic            fault,
   input logic            pc_load,
   input logic [XLEN-1:0] pc_out,
   input logic [XLEN-1:0] npc_out,
   input logic [XLEN-1:0] nnpc_out
);

   localparam logic [XLEN-1:0] STEP1      = XLEN'(PC_STEP);
   localparam logic [XLEN-1:0] HINT_PLAIN = {{(XLEN-1){1'b1}}, 1'b0};

   logic in_range;
   logic any_req;
   assign in_range = (32'(req_ctx) < NCTX);
   assign any_req  = req_yield || req_halt || req_restore;

   // R2: eligible zero-source yield releases the caller
   p_dealloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_yield && in_range && (yield_src == '0) && ctx_active[req_ctx] &&
      ctx_bind_ok[req_ctx] && ctx_dyn_alloc[req_ctx] && !ctx_halt_hold[req_ctx]
      |=> !ctx_active[$past(req_ctx)] && !fault);

   // R3: positive source outside the mask traps with code 2
   p_qual_exc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_yield && !yield_src[XLEN-1] && ((yield_src & ~yield_mask) != '0)
      |=> fault && (exc_code == 3'd2));

   // R4: plain hint or cleared intercept never traps
   p_hint_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_yield && yield_src[XLEN-1] &&
      ((yield_src == HINT_PLAIN) || !sched_intercept)
      |=> !fault && (exc_code == 3'd0));

   // R5: masked operand returned
   p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_yield |=> yield_result == $past(yield_src & yield_mask));

   // R6: halt of an active context stops it
   p_halt_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_halt && !req_yield && in_range && ctx_active[req_ctx]
      |=> !ctx_active[$past(req_ctx)] && !pc_load);

   // R7: restored PC triple is evenly spaced
   p_pc_triple_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (npc_out == pc_out + STEP1) && (nnpc_out == npc_out + STEP1));

   // R8: halt of a stopped context changes nothing
   p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_halt && !req_yield && in_range && !ctx_active[req_ctx]
      |=> $stable(ctx_active) && !pc_load && !fault && (exc_code == 3'd0));

   // R9: exception code holds through idle cycles; fault only after a yield
   p_exc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_req |=> $stable(exc_code) && !fault);

   p_fault_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_yield));

   // R10: yield wins over a simultaneous restore
   p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_yield && req_restore |=> !pc_load);

endmodule

bind thy_ctrl thy_ctrl_chk #(
   .NCTX   (NCTX),
   .XLEN   (XLEN),
   .PC_STEP(PC_STEP)
) u_chk (.*);

// File: tb/thy_ctrl_bench.sv
module thy_ctrl_bench;

   localparam int N  = 4;
   localparam int W  = 16;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_yield = 1'b0, req_halt = 1'b0, req_restore = 1'b0;
   logic [CW-1:0] req_ctx = '0;
   logic [W-1:0]  yield_src = '0, yield_mask = '0, cur_npc = '0;
   logic [N-1:0]  b_bind = '1, b_dyn = '1, b_hold = '0, b_dirty = '0;
   logic          b_icpt = 1'b0;
   logic [N-1:0]  ctx_active;
   logic [W-1:0]  yield_result;
   logic [2:0]    exc_code;
   logic          fault, pc_load;
   logic [CW-1:0] pc_load_ctx;
   logic [W-1:0]  pc_out, npc_out, nnpc_out;

   always #2 clk = ~clk;

   thy_ctrl #(
      .NCTX(N), .XLEN(W), .PC_STEP(4), .ACT_RST(4'b0011),
      .RESET_PC(16'h0100), .CHAIN_ADDERS(1'b0)
   ) u_thy_ctrl (
      .clk(clk), .rst_n(rst_n), .req_yield(req_yield), .req_halt(req_halt),
      .req_restore(req_restore), .req_ctx(req_ctx), .yield_src(yield_src),
      .yield_mask(yield_mask), .cur_npc(cur_npc), .ctx_bind_ok(b_bind),
      .ctx_dyn_alloc(b_dyn), .ctx_halt_hold(b_hold), .ctx_dirty(b_dirty),
      .sched_intercept(b_icpt), .ctx_active(ctx_active),
      .yield_result(yield_result), .exc_code(exc_code), .fault(fault),
      .pc_load(pc_load), .pc_load_ctx(pc_load_ctx), .pc_out(pc_out),
      .npc_out(npc_out), .nnpc_out(nnpc_out)
   );

   typedef struct {
      string         tag;
      int            due;
      logic          flt;
      logic [2:0]    exc;
      logic [W-1:0]  res;
      logic [N-1:0]  act;
      logic          load;
      logic [CW-1:0] lctx;
      logic [W-1:0]  pc, npc, nnpc;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   // reference state
   logic [N-1:0] m_act = 4'b0011;
   logic [W-1:0] m_rpc [N] = '{16'h0100, 16'h0100, 16'h0100, 16'h0100};
   logic [2:0]   m_exc = 3'd0;
   logic [W-1:0] m_res = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: applies one request, predicts the result, queues it
   task automatic issue(input bit y, input bit h, input bit r, input int c,
                        input logic [W-1:0] s, input logic [W-1:0] m,
                        input logic [W-1:0] np, input string tag);
      exp_t e;
      e.tag = tag; e.flt = 1'b0; e.load = 1'b0; e.lctx = '0;
      e.pc = '0; e.npc = '0; e.nnpc = '0;
      if (y) begin
         m_res = s & m;
         m_exc = 3'd0;
         if (s == '0) begin
            if (b_bind[c] && b_dyn[c] && !b_hold[c] && m_act[c]) m_act[c] = 1'b0;
         end else if (!s[W-1]) begin
            if ((s & ~m) != '0) m_exc = 3'd2;
         end else if (s != 16'hFFFE && b_icpt && b_dirty[c]) begin
            m_exc = 3'd4;
         end
         e.flt = (m_exc != 3'd0);
      end else if (h) begin
         if (m_act[c]) begin m_act[c] = 1'b0; m_rpc[c] = np; end
         m_exc = 3'd0;
      end else if (r) begin
         if (!m_act[c]) begin
            m_act[c] = 1'b1; e.load = 1'b1; e.lctx = CW'(c);
            e.pc = m_rpc[c]; e.npc = m_rpc[c] + 16'd4; e.nnpc = m_rpc[c] + 16'd8;
         end
         m_exc = 3'd0;
      end
      e.exc = m_exc; e.res = m_res; e.act = m_act;
      req_yield = y; req_halt = h; req_restore = r; req_ctx = CW'(c);
      yield_src = s; yield_mask = m; cur_npc = np;
      e.due = cyc + 1;
      q.push_back(e);
      @(negedge clk);
      req_yield = 1'b0; req_halt = 1'b0; req_restore = 1'b0;
   endtask

   // monitor: compares outputs with the queued prediction
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag, "fault", 32'(fault), 32'(e.flt));
         chk(e.tag, "exc_code", 32'(exc_code), 32'(e.exc));
         chk(e.tag, "yield_result", 32'(yield_result), 32'(e.res));
         chk(e.tag, "ctx_active", 32'(ctx_active), 32'(e.act));
         chk(e.tag, "pc_load", 32'(pc_load), 32'(e.load));
         if (e.load) begin
            chk(e.tag, "pc_load_ctx", 32'(pc_load_ctx), 32'(e.lctx));
            chk(e.tag, "pc_out", 32'(pc_out), 32'(e.pc));
            chk(e.tag, "npc_out", 32'(npc_out), 32'(e.npc));
            chk(e.tag, "nnpc_out", 32'(nnpc_out), 32'(e.nnpc));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "ctx_active", 32'(ctx_active), 32'h3);
      chk("R1", "fault", 32'(fault), 32'h0);
      chk("R1", "pc_load", 32'(pc_load), 32'h0);
      chk("R1", "exc_code", 32'(exc_code), 32'h0);

      issue(1, 0, 0, 0, 16'h0000, 16'h00FF, 16'h0, "R2");       // release ctx0
      issue(0, 0, 1, 0, 16'h0, 16'h0, 16'h0, "R1");             // reset restart addr
      b_hold = 4'b0010;
      issue(1, 0, 0, 1, 16'h0000, 16'h00FF, 16'h0, "R2");       // held: no change
      b_hold = 4'b0000;
      issue(1, 0, 0, 2, 16'h0000, 16'h00FF, 16'h0, "R2");       // inactive caller
      b_bind = 4'b1101;
      issue(1, 0, 0, 1, 16'h0000, 16'h00FF, 16'h0, "R2");       // unbound caller
      b_bind = 4'b1111;
      issue(1, 0, 0, 1, 16'h0030, 16'h00F0, 16'h0, "R3");       // within mask
      issue(1, 0, 0, 1, 16'h0130, 16'h00F0, 16'h0, "R3");       // outside mask
      issue(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");             // idle: hold code
      issue(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
      b_icpt = 1'b1; b_dirty = 4'b0010;
      issue(1, 0, 0, 1, 16'hFFFD, 16'h00FF, 16'h0, "R4");       // intercepted
      issue(1, 0, 0, 1, 16'hFFFE, 16'h00FF, 16'h0, "R4");       // plain hint
      issue(1, 0, 0, 0, 16'hFFFD, 16'h00FF, 16'h0, "R4");       // clean caller
      b_icpt = 1'b0;
      issue(1, 0, 0, 1, 16'hFFFD, 16'h0F0F, 16'h0, "R5");       // intercept off
      issue(0, 1, 0, 1, 16'h0, 16'h0, 16'h2468, "R6");          // halt active
      issue(0, 1, 0, 1, 16'h0, 16'h0, 16'h1111, "R8");          // halt again
      issue(0, 0, 1, 1, 16'h0, 16'h0, 16'h0, "R7");             // restore 0x2468
      issue(0, 0, 1, 1, 16'h0, 16'h0, 16'h0, "R8");             // restore active
      issue(1, 1, 0, 0, 16'h0004, 16'h000F, 16'h3333, "R10");   // yield beats halt
      issue(0, 1, 1, 3, 16'h0, 16'h0, 16'h4444, "R10");         // halt beats restore
      issue(0, 1, 0, 0, 16'h0, 16'h0, 16'hFFFC, "R6");          // wrap address
      issue(0, 0, 1, 0, 16'h0, 16'h0, 16'h0, "R7");
      issue(0, 0, 1, 3, 16'h0, 16'h0, 16'h0, "R7");             // reset address
      issue(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");

      repeat (3) @(negedge clk);
      chk("R9", "queue_empty", 32'(q.size()), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule